// File: doc/BRIEF.md
# Split-Enable Byte-Lane Bus Decoder

This block sits between a 16-bit host memory bus and a memory array. The bus has no byte-enable mask and no address bit for byte choice. It has two active-low select pins instead, one for the lower eight data bits and one for the upper eight, plus an active-low write-enable and an active-low output-enable. Every bus cycle is sorted into one of eight kinds: idle (standby), a word, low-byte or high-byte read, a word, low-byte or high-byte write, or an illegal pin combination.

From that sorting the block makes per-lane read and write strobes for the array. It drives each half of the bidirectional data bus from the array only when that half is being read, and leaves it floating otherwise. On a clock edge during a write it captures each written lane into a per-lane write register. The cycle kind and an illegal-cycle flag come out through a register, so that a checker can compare them one clock later.

Top module: `bylane_bus_decoder`

## Requirements
- R1: With both select pins low, the access covers both lanes. With only `sel_lo_n` low it covers bits 7:0 only. With only `sel_hi_n` low it covers bits 15:8 only.
- R2: A read needs `wen_n`=1 and `oen_n`=0, and pulses `arr_rd_stb` for each selected lane. A write needs `wen_n`=0 and `oen_n`=1, and pulses `arr_wr_stb` for each selected lane. Bit 0 of each strobe or enable vector is the low lane and bit 1 is the high lane.
- R3: During a read, `lane_oe` is set for each selected lane only, and that lane of `dq` carries the matching lane of `arr_rdata`. An unselected lane is not driven.
- R4: With both select pins high the cycle is standby, whatever `wen_n` and `oen_n` are. No strobe fires and neither lane is driven.
- R5: A cycle with at least one select pin low and `wen_n` equal to `oen_n` is illegal. It raises no strobe, drives no lane and sets `cyc_bad`.
- R6: `cyc_code` shows the cycle kind one clock after the pins are sampled. The codes are 0 standby, 1 word read, 2 low read, 3 high read, 4 word write, 5 low write, 6 high write and 7 illegal. `cyc_bad` is 1 exactly when the code is 7.
- R7: A write strobe fires only for a lane whose select pin is low. At the clock edge, `wdata` takes that lane of `dq`, and the other lane of `wdata` keeps its value.
- R8: While `rst_n` is low, `cyc_code`, `cyc_bad` and `wdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_lo_n | input | 1 | Active-low select of bits 7:0 |
| sel_hi_n | input | 1 | Active-low select of bits 15:8 |
| wen_n | input | 1 | Active-low write enable |
| oen_n | input | 1 | Active-low output enable |
| dq | inout | 16 | Bidirectional host data bus |
| arr_rdata | input | 16 | Read data from the array |
| arr_rd_stb | output | 2 | Per-lane read strobe |
| arr_wr_stb | output | 2 | Per-lane write strobe |
| lane_oe | output | 2 | Per-lane bus drive enable |
| wdata | output | 16 | Per-lane captured write data |
| cyc_code | output | 3 | Registered cycle kind |
| cyc_bad | output | 1 | Registered illegal-cycle flag |

## Verification
A half-width write and the hold of the opposite lane's write register land on the same clock edge. Two things could share a cycle in error: a lane write strobe firing for the wrong lane, or a lane output driver turning on during a write. To provoke this, the bench applies low-byte and high-byte writes with distinct patterns on both halves of `dq`. It then checks on the following edge that only the selected half of `wdata` changed. It also sweeps all sixteen pin combinations, so that read, write and illegal decoding are judged against each other in every cycle, with no strobe and drive active together.

// File: rtl/bld_pkg.sv
package bld_pkg;
   localparam int CODE_W = 3;
   localparam int N_LANE = 2;
   typedef enum logic [CODE_W-1:0] {
      CYC_IDLE = 3'd0,
      CYC_RD_W = 3'd1,
      CYC_RD_L = 3'd2,
      CYC_RD_H = 3'd3,
      CYC_WR_W = 3'd4,
      CYC_WR_L = 3'd5,
      CYC_WR_H = 3'd6,
      CYC_ILL  = 3'd7
   } cyc_e;
endpackage

// File: rtl/bld_classify.sv
module bld_classify
   import bld_pkg::*;
(
   input  logic [N_LANE-1:0] sel_n,
   input  logic              wen_n,
   input  logic              oen_n,
   output cyc_e              kind,
   output logic [N_LANE-1:0] rd_stb,
   output logic [N_LANE-1:0] wr_stb
);
   logic [N_LANE-1:0] pick;
   logic is_rd, is_wr;

   always_comb begin
      pick  = ~sel_n;
      is_rd = (pick != '0) && wen_n && !oen_n;
      is_wr = (pick != '0) && !wen_n && oen_n;
      if (pick == '0)
         kind = CYC_IDLE;
      else if (!is_rd && !is_wr)
         kind = CYC_ILL;
      else begin
         unique case (pick)
            2'b11:   kind = is_rd ? CYC_RD_W : CYC_WR_W;
            2'b01:   kind = is_rd ? CYC_RD_L : CYC_WR_L;
            default: kind = is_rd ? CYC_RD_H : CYC_WR_H;
         endcase
      end
      rd_stb = is_rd ? pick : '0;
      wr_stb = is_wr ? pick : '0;
   end
endmodule

// File: rtl/bld_lane.sv
module bld_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en,
   input  logic         wr_en,
   input  logic [W-1:0] rd_data,
   inout  wire  [W-1:0] dq,
   output logic [W-1:0] wr_q,
   output logic         oe
);
   assign oe = rd_en;
   assign dq = oe ? rd_data : {W{1'bz}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_q <= '0;
      else if (wr_en)
         wr_q <= dq;
   end

   AST_LANE_NO_DRIVE_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !oe) else $error("lane drives during write"); // R7
endmodule

// File: rtl/bylane_bus_decoder.sv
module bylane_bus_decoder
   import bld_pkg::*;
#(
   parameter int  LANE_W   = 8,
   parameter bit  REG_CODE = 1'b1,
   localparam int DW       = N_LANE * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_lo_n,
   input  logic              sel_hi_n,
   input  logic              wen_n,
   input  logic              oen_n,
   inout  wire  [DW-1:0]     dq,
   input  logic [DW-1:0]     arr_rdata,
   output logic [N_LANE-1:0] arr_rd_stb,
   output logic [N_LANE-1:0] arr_wr_stb,
   output logic [N_LANE-1:0] lane_oe,
   output logic [DW-1:0]     wdata,
   output logic [CODE_W-1:0] cyc_code,
   output logic              cyc_bad
);
   generate
      if (LANE_W < 1) begin : g_bad_w
         $error("LANE_W must be at least 1");
      end
   endgenerate

   logic [N_LANE-1:0] sel_n;
   cyc_e kind;
   assign sel_n = {sel_hi_n, sel_lo_n};

   bld_classify u_cls (
      .sel_n (sel_n),
      .wen_n (wen_n),
      .oen_n (oen_n),
      .kind  (kind),
      .rd_stb(arr_rd_stb),
      .wr_stb(arr_wr_stb)
   );

   genvar gi;
   generate
      for (gi = 0; gi < N_LANE; gi++) begin : g_lane
         bld_lane #(.W(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (arr_rd_stb[gi]),
            .wr_en  (arr_wr_stb[gi]),
            .rd_data(arr_rdata[gi*LANE_W +: LANE_W]),
            .dq     (dq[gi*LANE_W +: LANE_W]),
            .wr_q   (wdata[gi*LANE_W +: LANE_W]),
            .oe     (lane_oe[gi])
         );
         AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
            arr_wr_stb[gi] |-> !sel_n[gi]) else $error("stray write strobe"); // R7
      end
   endgenerate

   generate
      if (REG_CODE) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cyc_code <= CYC_IDLE;
               cyc_bad  <= 1'b0;
            end else begin
               cyc_code <= kind;
               cyc_bad  <= (kind == CYC_ILL);
            end
         end
      end else begin : g_comb
         always_comb begin
            cyc_code = rst_n ? kind : CYC_IDLE;
            cyc_bad  = rst_n && (kind == CYC_ILL);
         end
      end
   endgenerate

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_IDLE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_lo_n && sel_hi_n) |-> (lane_oe == '0 && arr_wr_stb == '0)) else $error("idle not quiet"); // R4
   AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!(sel_lo_n && sel_hi_n) && (wen_n == oen_n)) |-> (lane_oe == '0 && arr_wr_stb == '0 && arr_rd_stb == '0))
      else $error("illegal cycle acted"); // R5
   AST_NO_RD_WR_MIX: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_stb != '0) |-> (lane_oe == '0)) else $error("drive during write"); // R2
   AST_CODE_WORD_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && REG_CODE && $past(!sel_lo_n && !sel_hi_n && !wen_n && oen_n)) |-> (cyc_code == CYC_WR_W))
      else $error("word write code"); // R6
   AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_bad |-> (lane_oe == '0 || !REG_CODE || $past(kind) == CYC_ILL)) else $error("flag mismatch"); // R6
endmodule

// File: tb/sim_bylane_bus_decoder.sv
module sim_bylane_bus_decoder;
   localparam int CLK_P = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel_lo_n = 1, sel_hi_n = 1, wen_n = 1, oen_n = 1;
   logic [15:0] arr_rdata = '0, tb_dq = '0;
   logic tb_en = 1'b0;
   wire  [15:0] dq;
   logic [1:0] arr_rd_stb, arr_wr_stb, lane_oe;
   logic [15:0] wdata;
   logic [2:0] cyc_code;
   logic cyc_bad;

   assign dq = tb_en ? tb_dq : 16'bz;
   always #(CLK_P/2) clk = ~clk;

   bylane_bus_decoder u0 (
      .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n),
      .wen_n(wen_n), .oen_n(oen_n), .dq(dq), .arr_rdata(arr_rdata),
      .arr_rd_stb(arr_rd_stb), .arr_wr_stb(arr_wr_stb), .lane_oe(lane_oe),
      .wdata(wdata), .cyc_code(cyc_code), .cyc_bad(cyc_bad));

   int n_chk = 0, n_fail = 0;
   logic [15:0] exp_wq = '0;
   logic [34:0] sb_q[$];
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input bit lo, input bit hi, input bit we, input bit oe, input logic [15:0] d);
      logic [1:0] pick;
      logic [2:0] code;
      bit rd, wr;
      @(negedge clk);
      sel_lo_n = lo; sel_hi_n = hi; wen_n = we; oen_n = oe;
      pick = {~hi, ~lo};
      rd = (pick != 0) && we && !oe;
      wr = (pick != 0) && !we && oe;
      tb_en = wr;
      tb_dq = d;
      arr_rdata = ~d;
      if (pick == 0) code = 3'd0;
      else if (!rd && !wr) code = 3'd7;
      else code = (rd ? 3'd0 : 3'd3) + ((pick == 2'b11) ? 3'd1 : (pick == 2'b01) ? 3'd2 : 3'd3);
      #1;
      chk(arr_rd_stb == (rd ? pick : 2'b00), "R2 rd_stb", arr_rd_stb, rd ? pick : 2'b00);
      chk(arr_wr_stb == (wr ? pick : 2'b00), "R7 wr_stb", arr_wr_stb, wr ? pick : 2'b00);
      chk(lane_oe == (rd ? pick : 2'b00), "R3 lane_oe", lane_oe, rd ? pick : 2'b00);
      if (pick == 0) chk(lane_oe == 0 && arr_wr_stb == 0, "R4 standby quiet", {lane_oe, arr_wr_stb}, 0);
      if (code == 7) chk(lane_oe == 0 && arr_rd_stb == 0 && arr_wr_stb == 0, "R5 illegal quiet",
                         {lane_oe, arr_rd_stb, arr_wr_stb}, 0);
      if (rd && pick[0]) chk(dq[7:0] === arr_rdata[7:0], "R3 low lane data", dq[7:0], arr_rdata[7:0]);
      if (rd && pick[1]) chk(dq[15:8] === arr_rdata[15:8], "R1 high lane data", dq[15:8], arr_rdata[15:8]);
      if (wr && pick[0]) exp_wq[7:0] = d[7:0];
      if (wr && pick[1]) exp_wq[15:8] = d[15:8];
      sb_q.push_back({code, (code == 3'd7), exp_wq, 15'd0});
   endtask

   initial begin : monitor
      logic [34:0] it;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            chk(cyc_code == it[34:32], "R6 cycle code", cyc_code, it[34:32]);
            chk(cyc_bad == it[31], "R6 bad flag", cyc_bad, it[31]);
            chk(wdata == it[30:15], "R7 write register", wdata, it[30:15]);
         end
      end
   end

   initial begin : watchdog
      #(CLK_P * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1;
      chk(cyc_code == 0, "R8 reset code", cyc_code, 0);
      chk(cyc_bad == 0, "R8 reset flag", cyc_bad, 0);
      chk(wdata == 0, "R8 reset wdata", wdata, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1/R7: half-width writes must leave the other half alone
      apply(0, 0, 0, 1, 16'h1234);
      apply(0, 1, 0, 1, 16'hA5C3);
      apply(1, 0, 0, 1, 16'h5A3C);
      apply(1, 0, 0, 1, 16'h7E81);
      apply(0, 1, 0, 1, 16'h0F0F);
      // exhaustive pin sweep (R1..R5)
      for (int k = 0; k < 16; k++)
         apply(k[0], k[1], k[2], k[3], 16'h1111 * k[3:0] ^ 16'hC35A);
      // R4: standby with every wen/oen level
      apply(1, 1, 0, 0, 16'hFFFF);
      apply(1, 1, 1, 0, 16'hFFFF);
      // R5: illegal on a single lane
      apply(0, 1, 0, 0, 16'hBEEF);
      apply(1, 0, 1, 1, 16'hBEEF);
      apply(1, 1, 1, 1, 16'h0);
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule